// File: doc/BRIEF.md
# Auto-Delayed Conversion Start Gate

This block decides when a converter may begin a conversion. It serves two groups: single regular conversions, and injected sequences of one to four back-to-back conversions. Trigger pulses arrive from hardware sources. The gate turns each acceptable trigger into a one-cycle start pulse. It tracks the single conversion in flight, and it raises a result flag for each group when that group's work completes.

When the auto-delay mode is on, the block slows the converter to the pace at which software consumes results. After a regular conversion finishes, no new regular conversion may begin until the result is consumed. Software consumes it by reading the data register or by clearing the end-of-conversion flag. After the last conversion of an injected sequence, no new injected sequence may begin until software clears the end-of-sequence flag. A trigger that arrives while its group is held off is discarded, not queued. The conversions inside one injected sequence follow each other with no hold-off. When the mode is off, triggers pass through and the hold-off windows never open.

Top module: `conv_start_gate`

## Requirements
- R1: After reset, every output is 0.
- R2: A `reg_trig` pulse is accepted when the gate is idle, no injected sequence is active, and no regular hold-off applies. Acceptance gives one `reg_start` pulse on the next cycle, and `busy` rises in that same cycle.
- R3: `eoc_flag` rises in the cycle after a `conv_done` that ends a regular conversion. It falls in the cycle after `dr_read` or `eoc_clr`. When a done and a clear arrive together, the flag is set.
- R4: An accepted `inj_trig` latches `inj_len` and gives an `inj_start` pulse on the next cycle. `inj_len` value n means n+1 conversions. Every `conv_done` except the last one gives the next `inj_start` on the following cycle, with no wait.
- R5: `eos_flag` rises only in the cycle after the last `conv_done` of an injected sequence. It falls in the cycle after `eos_clr`. When a done and a clear arrive together, the flag is set.
- R6: With `auto_dly_en` high, a regular done opens the regular window (`reg_hold`=1). The window closes on `dr_read` or `eoc_clr`. A `reg_trig` that arrives while the window is open is dropped and is not remembered.
- R7: With `auto_dly_en` high, only the last done of an injected sequence opens the injected window (`inj_hold`=1). The window closes on `eos_clr`. An `inj_trig` that arrives while the window is open is dropped and is not remembered.
- R8: While `auto_dly_en` is low, both windows are closed one cycle later and stay closed. No trigger is blocked by a window in any cycle in which `auto_dly_en` is low.
- R9: If both triggers are eligible in the same cycle, only `inj_start` is given and the regular trigger is dropped.
- R10: `busy` stays high from a start pulse until a `conv_done`. Triggers that arrive while `busy` is high are dropped. A `conv_done` that arrives while `busy` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_dly_en | input | 1 | Enables the auto-delay hold-off windows |
| reg_trig | input | 1 | Hardware trigger pulse for a regular conversion |
| inj_trig | input | 1 | Hardware trigger pulse for an injected sequence |
| dr_read | input | 1 | Strobe for a data register read; consumes the regular result |
| eoc_clr | input | 1 | Strobe that clears the end-of-conversion flag |
| eos_clr | input | 1 | Strobe that clears the end-of-sequence flag |
| conv_done | input | 1 | The current conversion has completed |
| inj_len | input | LEN_W | Injected sequence length minus one |
| reg_start | output | 1 | One-cycle pulse that starts a regular conversion |
| inj_start | output | 1 | One-cycle pulse that starts an injected conversion |
| busy | output | 1 | A conversion is in progress |
| eoc_flag | output | 1 | A regular result is waiting |
| eos_flag | output | 1 | An injected sequence has completed |
| reg_hold | output | 1 | The regular hold-off window is open |
| inj_hold | output | 1 | The injected hold-off window is open |

## Verification
Every output is a register. The effect of any input sampled at a rising edge therefore shows up exactly one cycle later. This covers start pulses, the flags, the windows and the chained injected starts. The bench changes inputs just after a falling edge. It compares all seven outputs with its own cycle model at the next falling edge, so each result is read in the one cycle in which it is due. Dropped triggers are confirmed by the absence of a start pulse in that cycle, and also in later cycles after the window closes.

// File: rtl/csg_pkg.sv
package csg_pkg;
   localparam int NUM_LANES = 2;
   localparam int LANE_REG  = 0;
   localparam int LANE_INJ  = 1;

   typedef struct packed {
      logic inj_go;
      logic reg_go;
   } start_req_t;
endpackage

// File: rtl/csg_result_lane.sv
module csg_result_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_en,
   input  logic done_evt,
   input  logic clr_evt,
   output logic flag,
   output logic hold
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         hold <= 1'b0;
      end else begin
         if (done_evt)     flag <= 1'b1;
         else if (clr_evt) flag <= 1'b0;

         if (!auto_en)     hold <= 1'b0;
         else if (done_evt) hold <= 1'b1;
         else if (clr_evt) hold <= 1'b0;
      end
   end

   a_r8_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> !hold);
   a_r6_hold_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold) |-> $past(done_evt));
endmodule

// File: rtl/csg_inj_seq.sv
module csg_inj_seq #(
   parameter int LEN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seq_go,
   input  logic [LEN_W-1:0] len_in,
   input  logic             done_evt,
   output logic             in_seq,
   output logic             last_done,
   output logic             chain
);
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic             at_last;

   assign at_last   = (cnt_q == len_q);
   assign last_done = done_evt & in_seq & at_last;
   assign chain     = done_evt & in_seq & ~at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_seq <= 1'b0;
         cnt_q  <= '0;
         len_q  <= '0;
      end else if (seq_go) begin
         in_seq <= 1'b1;
         cnt_q  <= '0;
         len_q  <= len_in;
      end else if (last_done) begin
         in_seq <= 1'b0;
      end else if (chain) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      in_seq |-> (cnt_q <= len_q));
   a_r4_no_go_inside: assert property (@(posedge clk) disable iff (!rst_n)
      in_seq |-> !seq_go);
endmodule

// File: rtl/conv_start_gate.sv
module conv_start_gate #(
   parameter int LEN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_dly_en,
   input  logic             reg_trig,
   input  logic             inj_trig,
   input  logic             dr_read,
   input  logic             eoc_clr,
   input  logic             eos_clr,
   input  logic             conv_done,
   input  logic [LEN_W-1:0] inj_len,
   output logic             reg_start,
   output logic             inj_start,
   output logic             busy,
   output logic             eoc_flag,
   output logic             eos_flag,
   output logic             reg_hold,
   output logic             inj_hold
);
   import csg_pkg::*;

   localparam int MAX_SEQ = 1 << LEN_W;

   if (LEN_W < 1 || LEN_W > 4) begin : g_bad_len
      $error("LEN_W must be 1..4 (sequence up to %0d)", MAX_SEQ);
   end

   start_req_t           req;
   logic                 done_ok;
   logic                 in_seq;
   logic                 last_done;
   logic                 chain;
   logic [NUM_LANES-1:0] lane_done;
   logic [NUM_LANES-1:0] lane_clr;
   logic [NUM_LANES-1:0] lane_flag;
   logic [NUM_LANES-1:0] lane_hold;
   logic                 idle;

   assign done_ok = conv_done & busy;
   assign idle    = ~busy & ~in_seq;

   always_comb begin
      req.inj_go = inj_trig & idle & ~(auto_dly_en & lane_hold[LANE_INJ]);
      req.reg_go = reg_trig & idle & ~(auto_dly_en & lane_hold[LANE_REG])
                   & ~req.inj_go;
   end

   assign lane_done[LANE_REG] = done_ok & ~in_seq;
   assign lane_clr[LANE_REG]  = dr_read | eoc_clr;
   assign lane_done[LANE_INJ] = last_done;
   assign lane_clr[LANE_INJ]  = eos_clr;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      csg_result_lane u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .auto_en  (auto_dly_en),
         .done_evt (lane_done[i]),
         .clr_evt  (lane_clr[i]),
         .flag     (lane_flag[i]),
         .hold     (lane_hold[i])
      );
   end

   csg_inj_seq #(.LEN_W(LEN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .seq_go    (req.inj_go),
      .len_in    (inj_len),
      .done_evt  (done_ok),
      .in_seq    (in_seq),
      .last_done (last_done),
      .chain     (chain)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_start <= 1'b0;
         inj_start <= 1'b0;
         busy      <= 1'b0;
      end else begin
         reg_start <= req.reg_go;
         inj_start <= req.inj_go | chain;
         busy      <= (busy & ~done_ok) | req.reg_go | req.inj_go | chain;
      end
   end

   assign eoc_flag = lane_flag[LANE_REG];
   assign eos_flag = lane_flag[LANE_INJ];
   assign reg_hold = lane_hold[LANE_REG];
   assign inj_hold = lane_hold[LANE_INJ];

   a_r10_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_start || inj_start) |-> busy);
   a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !conv_done) |=> busy);
   a_r9_one_start: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_start && inj_start));
   a_r2_start_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
      reg_start |-> $past(reg_trig));
   a_r6_blocked_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      reg_start |-> !$past(auto_dly_en && reg_hold));
   a_r5_eos_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eos_flag) |-> $past(conv_done && busy));
endmodule

// File: tb/sim_conv_start_gate.sv
module sim_conv_start_gate;
   localparam int CLK_PERIOD = 10;
   localparam int LEN_W      = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic auto_dly_en = 0, reg_trig = 0, inj_trig = 0, dr_read = 0;
   logic eoc_clr = 0, eos_clr = 0, conv_done = 0;
   logic [LEN_W-1:0] inj_len = '0;
   logic reg_start, inj_start, busy, eoc_flag, eos_flag, reg_hold, inj_hold;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done_flag = 0;

   // reference state
   bit m_rs, m_is, m_busy, m_eoc, m_eos, m_rh, m_ih, m_seq;
   int m_cnt, m_len;

   always #(CLK_PERIOD/2) clk = ~clk;

   conv_start_gate #(.LEN_W(LEN_W)) u0 (.*);

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done_flag) begin
         done_flag = 1;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic int tag_of(int k); return k; endfunction

   task automatic chk(string tag, string nm, logic act, bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, nm, act, exp);
      end
   endtask

   task automatic model_step();
      bit idle, ig, rg, dok, rdone, idone, last, chn;
      idle  = !m_busy && !m_seq;
      ig    = inj_trig && idle && !(auto_dly_en && m_ih);
      rg    = reg_trig && idle && !(auto_dly_en && m_rh) && !ig;
      dok   = conv_done && m_busy;
      rdone = dok && !m_seq;
      idone = dok && m_seq;
      last  = (m_cnt == m_len);
      chn   = idone && !last;
      m_rs  = rg;
      m_is  = ig || chn;
      m_busy = (m_busy && !dok) || rg || ig || chn;
      if (ig) begin m_seq = 1; m_cnt = 0; m_len = int'(inj_len); end
      else if (idone && last) m_seq = 0;
      else if (chn) m_cnt++;
      if (rdone) m_eoc = 1; else if (dr_read || eoc_clr) m_eoc = 0;
      if (!auto_dly_en) m_rh = 0;
      else if (rdone) m_rh = 1; else if (dr_read || eoc_clr) m_rh = 0;
      if (idone && last) m_eos = 1; else if (eos_clr) m_eos = 0;
      if (!auto_dly_en) m_ih = 0;
      else if (idone && last) m_ih = 1; else if (eos_clr) m_ih = 0;
   endtask

   task automatic compare_all();
      chk("R2", "reg_start", reg_start, m_rs);
      chk("R4", "inj_start", inj_start, m_is);
      chk("R10", "busy", busy, m_busy);
      chk("R3", "eoc_flag", eoc_flag, m_eoc);
      chk("R5", "eos_flag", eos_flag, m_eos);
      chk("R6", "reg_hold", reg_hold, m_rh);
      chk("R7", "inj_hold", inj_hold, m_ih);
   endtask

   // drive a vector after a falling edge, compare at the next falling edge
   task automatic cyc(bit a, bit rt, bit it, bit rd, bit ec, bit sc, bit dn, int ln);
      auto_dly_en = a; reg_trig = rt; inj_trig = it; dr_read = rd;
      eoc_clr = ec; eos_clr = sc; conv_done = dn; inj_len = LEN_W'(ln);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      void'($urandom(32'd1234));
      m_rs = 0; m_is = 0; m_busy = 0; m_eoc = 0; m_eos = 0;
      m_rh = 0; m_ih = 0; m_seq = 0; m_cnt = 0; m_len = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      compare_all();
      rst_n = 1;
      @(negedge clk);

      // R2/R3/R6: regular start, done, window, dropped trigger, read closes
      cyc(1,1,0,0,0,0,0,0);
      chk("R2", "reg_start after trig", reg_start, 1'b1);
      cyc(1,1,0,0,0,0,0,0);            // R10: trigger while busy dropped
      chk("R10", "no start when busy", reg_start, 1'b0);
      cyc(1,0,0,0,0,0,1,0);
      chk("R6", "window opens", reg_hold, 1'b1);
      cyc(1,1,0,0,0,0,0,0);
      chk("R6", "trig in window dropped", reg_start, 1'b0);
      cyc(1,0,0,1,0,0,0,0);
      chk("R3", "read clears eoc", eoc_flag, 1'b0);
      cyc(1,0,0,0,0,0,0,0);
      chk("R6", "dropped trig not remembered", reg_start, 1'b0);
      cyc(1,0,0,0,0,0,1,0);            // R10: done while idle ignored
      chk("R10", "stray done ignored", eoc_flag, 1'b0);

      // R4/R5/R7: injected sequence of 3, chained starts
      cyc(1,0,1,0,0,0,0,2);
      chk("R4", "inj start", inj_start, 1'b1);
      cyc(1,0,0,0,0,0,1,0);
      chk("R4", "chained start", inj_start, 1'b1);
      chk("R7", "no window mid-seq", inj_hold, 1'b0);
      cyc(1,0,0,0,0,0,1,0);
      cyc(1,0,0,0,0,0,1,0);
      chk("R5", "eos on last", eos_flag, 1'b1);
      cyc(1,0,1,0,0,0,0,0);
      chk("R7", "inj trig in window dropped", inj_start, 1'b0);
      cyc(1,0,0,0,0,1,0,0);
      chk("R7", "eos_clr closes window", inj_hold, 1'b0);

      // R9: both eligible, injected wins
      cyc(1,1,1,0,0,0,0,0);
      chk("R9", "inj wins", inj_start, 1'b1);
      chk("R9", "reg dropped", reg_start, 1'b0);
      cyc(1,0,0,0,0,0,1,0);
      cyc(1,0,0,0,0,1,0,0);

      // R8: auto off, windows stay closed
      cyc(0,1,0,0,0,0,0,0);
      cyc(0,0,0,0,0,0,1,0);
      chk("R8", "no window when off", reg_hold, 1'b0);
      cyc(0,1,0,0,0,0,0,0);
      chk("R8", "trig passes when off", reg_start, 1'b1);
      cyc(0,0,0,0,0,0,1,0);
      // R3: set wins over clear
      cyc(1,1,0,0,0,0,0,0);
      cyc(1,0,0,0,1,0,1,0);
      chk("R3", "set beats clear", eoc_flag, 1'b1);
      cyc(1,0,0,0,1,0,0,0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         automatic bit a = ($urandom % 16) != 0;
         cyc(a, ($urandom%10)<3, ($urandom%10)<2, ($urandom%10)<1,
             ($urandom%10)<1, ($urandom%10)<2, ($urandom%10)<4, int'($urandom%4));
      end

      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule